// File: doc/BRIEF.md
# Battery protection FET enable controller

This block sits between a pack monitor's protection logic and the high-side gate drivers of a battery pack. It decides on every clock cycle whether the charge switch and the discharge switch may conduct. It weighs these inputs together:

- per-direction fault flags, honoured only when autonomous recovery is on;
- two host off-request pins;
- off-requests that host subcommands latch;
- the sleep state;
- in a series topology, the magnitude and sign of the pack current, which can force an off switch on to protect its body diode.

Each switch is tracked by its own four-state machine with the states SW_DISABLED, SW_OFF, SW_ON and SW_RESCUE:

- DISABLED: the global enable is low. It is also the reset state.
- OFF: some block is active.
- ON: nothing blocks the switch.
- RESCUE: a fault or sleep block is overridden by body-diode current.

The transitions are:

- EN_UP: from DISABLED to the target state, when the global enable rises.
- BLOCK: from ON or RESCUE to OFF.
- RELEASE: from OFF or RESCUE to ON.
- RESCUE_IN: from OFF or ON to RESCUE.
- RESCUE_OUT: from RESCUE to OFF, when the current falls or a host block appears.
- EN_DOWN: from any state to DISABLED.

A separate register selects follower drive or pump drive for the discharge gate.

Top module: `fet_enable_ctrl`

## Requirements
- R1: While reset is asserted, chg_en and dsg_en are 0. Both host latches reset to the released state, so with no blocks both enables go to 1 one clock edge after reset is released.
- R2: When glob_en is 0, chg_en, dsg_en and dsg_follow are 0 one edge later, whatever the other inputs are.
- R3: With auto_en=1, chg_fault turns only chg_en off and dsg_fault turns only dsg_en off, one edge after the flag. The switch returns on one edge after the flag clears. With auto_en=0, the fault flags have no effect.
- R4: Code 16'h0093 latches the discharge switch off, 16'h0094 latches the charge switch off and 16'h0095 latches both off. A latched switch stays off until released. The enable changes two edges after the cycle in which cmd_valid was high.
- R5: Code 16'h0097 sets both latches from cmd_arg. Bit 0 controls charge and bit 1 controls discharge. A bit of 1 releases that switch and a bit of 0 holds it off.
- R6: Code 16'h0096 releases both latches. Each switch then turns on only if no honoured fault, sleep gate or off pin still blocks it.
- R7: chg_off_pin and dsg_off_pin force the matching enable to 0 one edge later for as long as they are held. The switch returns one edge after release if nothing else blocks it.
- R8: A command with any other code leaves both latches unchanged.
- R9: With sleep=1 and chg_in_sleep=0, chg_en is 0 and dsg_en is unaffected. With chg_in_sleep=1, sleep does not gate charge.
- R10: dsg_follow is 1 one edge after a cycle in which glob_en, sleep and follower_in_sleep are all 1 and current is not negative. A negative current (discharge) selects pump drive (0) on the next edge.
- R11: With series_topo=1 and auto_en=1, a switch that is off only through a fault or the sleep gate is forced on when current > bd_thresh (for discharge) or current < -bd_thresh (for charge). Current is signed, positive for charging, and the comparisons are strict.
- R12: The body-diode override does not act in the parallel topology (series_topo=0) or with auto_en=0. It never overrides an off pin or a host latch.
- R13: status[0] equals chg_en and status[1] equals dsg_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glob_en | input | 1 | Global switch-control enable |
| auto_en | input | 1 | Autonomous fault handling and recovery enable |
| series_topo | input | 1 | 1 = series switches, 0 = separate charge and load paths |
| chg_in_sleep | input | 1 | Allow charge switch in sleep |
| follower_in_sleep | input | 1 | Allow follower drive of the discharge switch in sleep |
| chg_fault | input | 1 | A fault mapped to the charge switch is active |
| dsg_fault | input | 1 | A fault mapped to the discharge switch is active |
| chg_off_pin | input | 1 | Host request holding the charge switch off |
| dsg_off_pin | input | 1 | Host request holding the discharge switch off |
| cmd_valid | input | 1 | Subcommand strobe |
| cmd_code | input | 16 | Subcommand code |
| cmd_arg | input | 2 | Operand of the individual-set command |
| sleep | input | 1 | Device is in sleep mode |
| current | input | 16 | Signed pack current, positive = charging |
| bd_thresh | input | 16 | Positive body-diode current threshold |
| chg_en | output | 1 | Charge switch enable |
| dsg_en | output | 1 | Discharge switch enable |
| dsg_follow | output | 1 | 1 = follower drive, 0 = pump drive for the discharge switch |
| status | output | 2 | {dsg_en, chg_en} |

## Verification
A switch machine stuck in the wrong state shows directly on chg_en or dsg_en one edge after the input that should have moved it. Every state maps to one enable level, so no error stays hidden for longer than a cycle. A wrong host latch hides behind any other block that is active at the same time. For that reason the bench clears every other block and then reads the enables two edges after the command. Latch persistence and release are shown by a later release or an all-on command. A rescue decision that is wrong only near the threshold is exposed by samples at exactly the threshold and one count beyond it.

// File: rtl/fet_ctrl_pkg.sv
package fet_ctrl_pkg;
    localparam int CODE_W = 16;

    localparam logic [CODE_W-1:0] CMD_DSG_OFF = 16'h0093;
    localparam logic [CODE_W-1:0] CMD_CHG_OFF = 16'h0094;
    localparam logic [CODE_W-1:0] CMD_ALL_OFF = 16'h0095;
    localparam logic [CODE_W-1:0] CMD_ALL_ON  = 16'h0096;
    localparam logic [CODE_W-1:0] CMD_SET_EACH = 16'h0097;

    typedef enum logic [1:0] {
        SW_DISABLED = 2'd0,
        SW_OFF      = 2'd1,
        SW_ON       = 2'd2,
        SW_RESCUE   = 2'd3
    } sw_state_t;
endpackage

// File: rtl/fet_host_latch.sv
module fet_host_latch
    import fet_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [1:0]        cmd_arg,
    output logic              chg_hold,
    output logic              dsg_hold
);
    logic chg_nxt, dsg_nxt;

    always_comb begin
        chg_nxt = chg_hold;
        dsg_nxt = dsg_hold;
        if (cmd_valid) begin
            unique case (cmd_code)
                CMD_DSG_OFF:  dsg_nxt = 1'b1;
                CMD_CHG_OFF:  chg_nxt = 1'b1;
                CMD_ALL_OFF: begin
                    chg_nxt = 1'b1;
                    dsg_nxt = 1'b1;
                end
                CMD_ALL_ON: begin
                    chg_nxt = 1'b0;
                    dsg_nxt = 1'b0;
                end
                CMD_SET_EACH: begin
                    chg_nxt = ~cmd_arg[0];
                    dsg_nxt = ~cmd_arg[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chg_hold <= 1'b0;
            dsg_hold <= 1'b0;
        end else begin
            chg_hold <= chg_nxt;
            dsg_hold <= dsg_nxt;
        end
    end
endmodule

// File: rtl/fet_bd_detect.sv
module fet_bd_detect #(
    parameter int CUR_W = 16
) (
    input  logic signed [CUR_W-1:0] current,
    input  logic signed [CUR_W-1:0] bd_thresh,
    input  logic                    series_topo,
    input  logic                    auto_en,
    output logic                    chg_rescue,
    output logic                    dsg_rescue,
    output logic                    discharging
);
    localparam int EXT_W = CUR_W + 1;

    logic signed [EXT_W-1:0] cur_x, thr_x, thr_neg;

    always_comb begin
        cur_x   = EXT_W'(current);
        thr_x   = EXT_W'(bd_thresh);
        thr_neg = -thr_x;
        dsg_rescue  = series_topo && auto_en && (cur_x > thr_x);
        chg_rescue  = series_topo && auto_en && (cur_x < thr_neg);
        discharging = current < 0;
    end
endmodule

// File: rtl/fet_switch_fsm.sv
module fet_switch_fsm
    import fet_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic glob_en,
    input  logic hard_block,
    input  logic soft_block,
    input  logic rescue_req,
    output logic sw_en
);
    sw_state_t state, state_nxt;
    sw_state_t target;

    always_comb begin
        if (hard_block)
            target = SW_OFF;
        else if (!soft_block)
            target = SW_ON;
        else if (rescue_req)
            target = SW_RESCUE;
        else
            target = SW_OFF;

        state_nxt = state;
        unique case (state)
            SW_DISABLED: if (glob_en) state_nxt = target;
            SW_OFF:      state_nxt = glob_en ? target : SW_DISABLED;
            SW_ON:       state_nxt = glob_en ? target : SW_DISABLED;
            SW_RESCUE: begin
                if (!glob_en)
                    state_nxt = SW_DISABLED;
                else if (hard_block || !rescue_req)
                    state_nxt = soft_block || hard_block ? SW_OFF : SW_ON;
                else
                    state_nxt = target;
            end
            default:     state_nxt = SW_DISABLED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SW_DISABLED;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            SW_ON, SW_RESCUE: sw_en = 1'b1;
            default:          sw_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/fet_enable_ctrl.sv
module fet_enable_ctrl
    import fet_ctrl_pkg::*;
#(
    parameter int CUR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    glob_en,
    input  logic                    auto_en,
    input  logic                    series_topo,
    input  logic                    chg_in_sleep,
    input  logic                    follower_in_sleep,
    input  logic                    chg_fault,
    input  logic                    dsg_fault,
    input  logic                    chg_off_pin,
    input  logic                    dsg_off_pin,
    input  logic                    cmd_valid,
    input  logic [CODE_W-1:0]       cmd_code,
    input  logic [1:0]              cmd_arg,
    input  logic                    sleep,
    input  logic signed [CUR_W-1:0] current,
    input  logic signed [CUR_W-1:0] bd_thresh,
    output logic                    chg_en,
    output logic                    dsg_en,
    output logic                    dsg_follow,
    output logic [1:0]              status
);
    localparam int NSW = 2;

    logic chg_hold, dsg_hold;
    logic chg_rescue, dsg_rescue, discharging;
    logic [NSW-1:0] hard_v, soft_v, resc_v, en_v;

    fet_host_latch i_latch (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_arg(cmd_arg), .chg_hold(chg_hold), .dsg_hold(dsg_hold)
    );

    fet_bd_detect #(.CUR_W(CUR_W)) i_bd (
        .current(current), .bd_thresh(bd_thresh), .series_topo(series_topo),
        .auto_en(auto_en), .chg_rescue(chg_rescue), .dsg_rescue(dsg_rescue),
        .discharging(discharging)
    );

    // index 0 = charge switch, index 1 = discharge switch
    always_comb begin
        hard_v[0] = chg_hold || chg_off_pin;
        hard_v[1] = dsg_hold || dsg_off_pin;
        soft_v[0] = (auto_en && chg_fault) || (sleep && !chg_in_sleep);
        soft_v[1] = auto_en && dsg_fault;
        resc_v[0] = chg_rescue;
        resc_v[1] = dsg_rescue;
    end

    for (genvar g = 0; g < NSW; g++) begin : g_sw
        fet_switch_fsm i_fsm (
            .clk(clk), .rst_n(rst_n), .glob_en(glob_en),
            .hard_block(hard_v[g]), .soft_block(soft_v[g]),
            .rescue_req(resc_v[g]), .sw_en(en_v[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dsg_follow <= 1'b0;
        else        dsg_follow <= glob_en && sleep && follower_in_sleep && !discharging;
    end

    assign chg_en = en_v[0];
    assign dsg_en = en_v[1];
    assign status = en_v;
endmodule

// File: rtl/fet_enable_ctrl_chk.sv
module fet_enable_ctrl_chk
    import fet_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              glob_en,
    input logic              auto_en,
    input logic              series_topo,
    input logic              chg_in_sleep,
    input logic              sleep,
    input logic              chg_fault,
    input logic              dsg_fault,
    input logic              chg_off_pin,
    input logic              dsg_off_pin,
    input logic              cmd_valid,
    input logic [CODE_W-1:0] cmd_code,
    input logic              chg_en,
    input logic              dsg_en,
    input logic              dsg_follow
);
    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> (!chg_en && !dsg_en && !dsg_follow)); // R2
    AST_CHG_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && chg_fault && !series_topo) |=> !chg_en); // R3
    AST_DSG_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && dsg_fault && !series_topo) |=> !dsg_en); // R3
    AST_ALL_OFF_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_ALL_OFF) |=> ##1 (!chg_en && !dsg_en)); // R4
    AST_CHG_PIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        chg_off_pin |=> !chg_en); // R7
    AST_DSG_PIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        dsg_off_pin |=> !dsg_en); // R7
    AST_SLEEP_CHG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !chg_in_sleep && !series_topo) |=> !chg_en); // R9
    AST_FOLLOW_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |=> !dsg_follow); // R10
endmodule

bind fet_enable_ctrl fet_enable_ctrl_chk i_chk (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .auto_en(auto_en),
    .series_topo(series_topo), .chg_in_sleep(chg_in_sleep), .sleep(sleep),
    .chg_fault(chg_fault), .dsg_fault(dsg_fault), .chg_off_pin(chg_off_pin),
    .dsg_off_pin(dsg_off_pin), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .chg_en(chg_en), .dsg_en(dsg_en), .dsg_follow(dsg_follow)
);

// File: tb/test_fet_enable_ctrl.sv
`timescale 1ns/1ps
module test_fet_enable_ctrl;
    logic clk = 1'b0;
    logic rst_n;
    logic glob_en, auto_en, series_topo, chg_in_sleep, follower_in_sleep;
    logic chg_fault, dsg_fault, chg_off_pin, dsg_off_pin, cmd_valid, sleep;
    logic [15:0] cmd_code;
    logic [1:0] cmd_arg;
    logic signed [15:0] current, bd_thresh;
    logic chg_en, dsg_en, dsg_follow;
    logic [1:0] status;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fet_enable_ctrl i_fet_enable_ctrl (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .auto_en(auto_en),
        .series_topo(series_topo), .chg_in_sleep(chg_in_sleep),
        .follower_in_sleep(follower_in_sleep), .chg_fault(chg_fault),
        .dsg_fault(dsg_fault), .chg_off_pin(chg_off_pin), .dsg_off_pin(dsg_off_pin),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_arg(cmd_arg),
        .sleep(sleep), .current(current), .bd_thresh(bd_thresh),
        .chg_en(chg_en), .dsg_en(dsg_en), .dsg_follow(dsg_follow), .status(status)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // checks both enables and the status word (R13) together
    task automatic chk_en(input string req, input logic c, input logic d);
        chk(req, {2'b00, dsg_en, chg_en}, {2'b00, d, c});
        chk("R13 status", {2'b00, status}, {2'b00, d, c});
    endtask

    task automatic idle();
        glob_en = 1; auto_en = 1; series_topo = 0; chg_in_sleep = 0;
        follower_in_sleep = 0; chg_fault = 0; dsg_fault = 0; chg_off_pin = 0;
        dsg_off_pin = 0; cmd_valid = 0; cmd_code = 16'h0; cmd_arg = 2'b00;
        sleep = 0; current = 16'sd0; bd_thresh = 16'sd100;
    endtask

    task automatic send(input logic [15:0] code, input logic [1:0] arg);
        cmd_valid = 1; cmd_code = code; cmd_arg = arg;
        step(1);
        cmd_valid = 0;
        step(1);
    endtask

    task automatic release_all();
        idle();
        send(16'h0096, 2'b00);
        step(1);
    endtask

    task automatic t_reset();
        idle();
        rst_n = 0;
        step(2);
        chk_en("R1 in reset", 1'b0, 1'b0);
        rst_n = 1;
        step(1);
        chk_en("R1 after reset", 1'b1, 1'b1);
    endtask

    task automatic t_global();
        release_all();
        sleep = 1; follower_in_sleep = 1; glob_en = 0;
        step(1);
        chk_en("R2 global off", 1'b0, 1'b0);
        chk("R2 follow", {3'b0, dsg_follow}, 4'b0);
        glob_en = 1; sleep = 0;
        step(1);
        chk_en("R2 global back", 1'b1, 1'b1);
    endtask

    task automatic t_fault();
        release_all();
        chg_fault = 1;
        step(1);
        chk_en("R3 chg fault", 1'b0, 1'b1);
        chg_fault = 0; dsg_fault = 1;
        step(1);
        chk_en("R3 dsg fault", 1'b1, 1'b0);
        dsg_fault = 0;
        step(1);
        chk_en("R3 recover", 1'b1, 1'b1);
        auto_en = 0; chg_fault = 1; dsg_fault = 1;
        step(1);
        chk_en("R3 manual ignores faults", 1'b1, 1'b1);
    endtask

    task automatic t_latch();
        release_all();
        send(16'h0093, 2'b00);
        chk_en("R4 dsg latch", 1'b1, 1'b0);
        send(16'h0094, 2'b00);
        chk_en("R4 chg latch", 1'b0, 1'b0);
        step(5);
        chk_en("R4 persists", 1'b0, 1'b0);
        release_all();
        send(16'h0095, 2'b00);
        chk_en("R4 all off", 1'b0, 1'b0);
    endtask

    task automatic t_each();
        release_all();
        send(16'h0097, 2'b01);
        chk_en("R5 arg 01", 1'b1, 1'b0);
        send(16'h0097, 2'b10);
        chk_en("R5 arg 10", 1'b0, 1'b1);
        send(16'h0097, 2'b11);
        chk_en("R5 arg 11", 1'b1, 1'b1);
    endtask

    task automatic t_all_on();
        release_all();
        send(16'h0095, 2'b00);
        chg_fault = 1; dsg_off_pin = 1;
        send(16'h0096, 2'b00);
        chk_en("R6 blocked after all-on", 1'b0, 1'b0);
        chg_fault = 0; dsg_off_pin = 0;
        step(1);
        chk_en("R6 release", 1'b1, 1'b1);
    endtask

    task automatic t_pins();
        release_all();
        chg_off_pin = 1;
        step(1);
        chk_en("R7 chg pin", 1'b0, 1'b1);
        chg_off_pin = 0; dsg_off_pin = 1;
        step(1);
        chk_en("R7 dsg pin", 1'b1, 1'b0);
        dsg_off_pin = 0;
        step(1);
        chk_en("R7 pins released", 1'b1, 1'b1);
    endtask

    task automatic t_unknown();
        release_all();
        send(16'h0098, 2'b00);
        chk_en("R8 unknown no off", 1'b1, 1'b1);
        send(16'h0093, 2'b00);
        send(16'h0090, 2'b11);
        chk_en("R8 unknown no release", 1'b1, 1'b0);
        send(16'h0197, 2'b11);
        chk_en("R8 near code", 1'b1, 1'b0);
    endtask

    task automatic t_sleep();
        release_all();
        sleep = 1;
        step(1);
        chk_en("R9 sleep gate", 1'b0, 1'b1);
        chg_in_sleep = 1;
        step(1);
        chk_en("R9 charge allowed", 1'b1, 1'b1);
    endtask

    task automatic t_follow();
        release_all();
        sleep = 1; follower_in_sleep = 1; chg_in_sleep = 1;
        step(1);
        chk("R10 follower", {3'b0, dsg_follow}, 4'b1);
        current = -16'sd1;
        step(1);
        chk("R10 pump on discharge", {3'b0, dsg_follow}, 4'b0);
        current = 16'sd5;
        step(1);
        chk("R10 back to follower", {3'b0, dsg_follow}, 4'b1);
        follower_in_sleep = 0;
        step(1);
        chk("R10 bit clear", {3'b0, dsg_follow}, 4'b0);
    endtask

    task automatic t_rescue();
        release_all();
        series_topo = 1; dsg_fault = 1; current = 16'sd100;
        step(1);
        chk_en("R11 at threshold", 1'b1, 1'b0);
        current = 16'sd101;
        step(1);
        chk_en("R11 dsg rescue", 1'b1, 1'b1);
        current = 16'sd0;
        step(1);
        chk_en("R11 rescue ends", 1'b1, 1'b0);
        dsg_fault = 0; chg_fault = 1; current = -16'sd100;
        step(1);
        chk_en("R11 neg threshold", 1'b0, 1'b1);
        current = -16'sd101;
        step(1);
        chk_en("R11 chg rescue", 1'b1, 1'b1);
    endtask

    task automatic t_rescue_block();
        release_all();
        dsg_fault = 1; current = 16'sd500;
        step(1);
        chk_en("R12 parallel", 1'b1, 1'b0);
        series_topo = 1; dsg_off_pin = 1;
        step(1);
        chk_en("R12 pin wins", 1'b1, 1'b0);
        dsg_off_pin = 0;
        send(16'h0093, 2'b00);
        chk_en("R12 latch wins", 1'b1, 1'b0);
        release_all();
        series_topo = 1; auto_en = 0; sleep = 1; current = -16'sd500;
        step(1);
        chk_en("R12 manual no rescue", 1'b0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_global();
        t_fault();
        t_latch();
        t_each();
        t_all_on();
        t_pins();
        t_unknown();
        t_sleep();
        t_follow();
        t_rescue();
        t_rescue_block();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule